// File: doc/BRIEF.md
# Converter Command Sequencer

This block is the control state machine of a self-calibrating sampling converter. A host writes a three-bit command together with a mode bit and a two-bit acquisition select. The sequencer then runs timed phases, all counted in converter clocks. These phases are calibration, offset zeroing, acquisition and conversion. Host software follows progress on one active-low ready line, `rdy_n`.

The sync pin is bidirectional. In free-running mode the block drives the pin high for as long as a conversion runs. A host read re-arms the next conversion, and a table picks the acquisition length. In externally-timed mode the pin is an input. A rising edge on it ends acquisition and starts the conversion.

The datapath is a stub. When a conversion completes, the supplied result word is captured into `result_q`. Each timed phase ends with a single-cycle `phase_done` pulse, so phase lengths can be checked to the exact cycle.

Top module: `conv_seq_ctrl`

## Requirements
- R1: After reset `rdy_n` is 1 (sleep state), the mode is externally-timed so `sync_oe` is 0, `sync_out` is 0, `result_q` is 0 and `phase_done` is 0.
- R2: Command code 000 (sleep) sets `rdy_n` to 1 from the cycle after the write, and it stays 1 until another command is accepted. Any accepted command other than sleep, calibration or zeroing drives `rdy_n` to 0 in the cycle after the write.
- R3: Command 001 (full calibration) holds `rdy_n` at 1 for exactly CAL_CLKS cycles, starting with the cycle after the write. `rdy_n` then returns to 0. `phase_done` pulses once, in the last high cycle.
- R4: Command 010 (offset zeroing) behaves like R3, with a length of ZERO_CLKS cycles.
- R5: Command 011 (idle) is accepted in every state. In the cycle after the write, `rdy_n` and `sync_out` are 0, and the phase in progress is abandoned without loading `result_q`.
- R6: In free-running mode (mode bit 0) with command 100 (start) loaded, a `rd_done` pulse raises `rdy_n` for exactly ACQ+CONV_CLKS cycles. ACQ is 9, 15, 47 or 79 for select 00, 01, 10 or 11. `sync_out` is high for the last CONV_CLKS of those cycles, and `phase_done` pulses twice.
- R7: When a conversion completes, `rdy_n` and `sync_out` fall together. `result_q` then holds the `conv_result` value that was present in the final conversion cycle.
- R8: `sync_oe` equals the inverse of the latched mode bit. While `sync_oe` is 0, `sync_out` stays 0.
- R9: In externally-timed mode (mode bit 1) the select bits are ignored. A synchronized rising edge on `sync_in` while armed raises `rdy_n` for exactly CONV_CLKS cycles. A `rd_done` while armed raises `rdy_n` but starts no conversion, and `rdy_n` then stays 1 until a conversion completes.
- R10: During calibration, zeroing, acquisition or conversion, every command except idle is ignored. This covers the phase length, the mode bit and the select bits.
- R11: Command codes 101, 110 and 111 are ignored. They leave the state, `rdy_n` and the latched mode unchanged.
- R12: In free-running mode, edges on `sync_in` start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_cmd | input | 3 | Command code |
| cfg_ext_sync | input | 1 | Mode bit: 1 externally-timed, 0 free-running |
| cfg_acq_sel | input | 2 | Acquisition length select |
| rd_done | input | 1 | One-cycle pulse at the end of a host result read |
| conv_result | input | RES_W | Result word from the conversion datapath |
| sync_in | input | 1 | Sync pad input value |
| sync_out | output | 1 | Sync pad output value |
| sync_oe | output | 1 | Sync pad output enable |
| rdy_n | output | 1 | Active-low ready |
| result_q | output | RES_W | Captured conversion result |
| phase_done | output | 1 | Single-cycle end-of-phase pulse |

## Verification
The bench builds the block with CAL_CLKS reduced to 300. Every other parameter keeps its default: the 9/15/47/79 acquisition table, a 44-clock conversion and a 78-clock zeroing phase. A full calibration window can therefore be measured to the cycle within a short run, and all four acquisition entries are still exercised at their real lengths. The scoreboard measures each high period of `rdy_n`, the `sync_out` time inside it, the `phase_done` count and the captured result. Commands are injected in the middle of phases to probe the abort and ignore rules.

// File: rtl/conv_seq_pkg.sv
// Shared types for the converter command sequencer.
// Assumes: command codes are fixed by the host software interface.
package conv_seq_pkg;

    typedef enum logic [2:0] {
        CMD_SLEEP = 3'b000,
        CMD_CAL   = 3'b001,
        CMD_ZERO  = 3'b010,
        CMD_IDLE  = 3'b011,
        CMD_START = 3'b100
    } cmd_e;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_IDLE,
        ST_CAL,
        ST_ZERO,
        ST_ARMED,
        ST_ACQ,
        ST_CONV
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/conv_sync_rise.sv
// Synchronizes the sync pad input and flags its rising edge for one cycle.
// Assumes: STAGES >= 2; the pad is asynchronous to clk.
module conv_sync_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh;

    // first flop of the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= pin;
    end

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_chain
            // remaining synchronizer and history flops
            always_ff @(posedge clk) begin
                if (!rst_n) sh[g] <= 1'b0;
                else        sh[g] <= sh[g-1];
            end
        end
    endgenerate

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    AST_SYNC_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R9

endmodule

// File: rtl/conv_acq_lut.sv
// Maps the two-bit acquisition select onto a clock count.
// Assumes: every entry fits in CW bits.
module conv_acq_lut #(
    parameter int unsigned T0 = 9,
    parameter int unsigned T1 = 15,
    parameter int unsigned T2 = 47,
    parameter int unsigned T3 = 79,
    parameter int          CW = 7
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] cycles
);
    // pick the table entry
    always_comb begin
        case (sel)
            2'd0:    cycles = CW'(T0);
            2'd1:    cycles = CW'(T1);
            2'd2:    cycles = CW'(T2);
            default: cycles = CW'(T3);
        endcase
    end
endmodule

// File: rtl/conv_phase_timer.sv
// Down-counter for one timed phase. A load of N makes `running` true for
// exactly N cycles; `term` marks the last of them.
// Assumes: load_val >= 1; load has priority over abort.
module conv_phase_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          abort,
    output logic          running,
    output logic          term
);
    logic [CW-1:0] cnt;

    // count the phase down, stopping at its terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= load_val - CW'(1);
            running <= 1'b1;
        end else if (abort) begin
            running <= 1'b0;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - CW'(1);
        end
    end

    assign term = running && (cnt == '0);

    AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load && !abort && cnt != '0) |=> (running && cnt == $past(cnt) - CW'(1))); // R3
    AST_TMR_LOAD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> running); // R4

endmodule

// File: rtl/conv_seq_ctrl.sv
// Command-driven sequencer of a sampling converter: decodes host commands,
// runs calibration / zeroing / acquisition / conversion phases, drives the
// active-low ready line and the bidirectional sync pad, captures results.
// Assumes: cfg_wr and rd_done are single-cycle strobes already aligned to clk.
module conv_seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int RES_W       = 13,
    parameter int ACQ_T0      = 9,
    parameter int ACQ_T1      = 15,
    parameter int ACQ_T2      = 47,
    parameter int ACQ_T3      = 79,
    parameter int CONV_CLKS   = 44,
    parameter int ZERO_CLKS   = 78,
    parameter int CAL_CLKS    = 4946,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_cmd,
    input  logic             cfg_ext_sync,
    input  logic [1:0]       cfg_acq_sel,
    input  logic             rd_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             sync_in,
    output logic             sync_out,
    output logic             sync_oe,
    output logic             rdy_n,
    output logic [RES_W-1:0] result_q
    ,output logic            phase_done
);
    localparam int unsigned MAX_ACQ = max2(max2(ACQ_T0, ACQ_T1), max2(ACQ_T2, ACQ_T3));
    localparam int unsigned MAX_ALL = max2(max2(MAX_ACQ, CONV_CLKS), max2(ZERO_CLKS, CAL_CLKS));
    localparam int          CW      = $clog2(MAX_ALL + 1);

    seq_state_e       state, nxt_state;
    logic             rdy_q, nxt_rdy;
    logic             drv_q, nxt_drv;
    logic             ext_q;
    logic [1:0]       acq_q;
    logic             ld_res;
    logic             t_load, t_abort, t_run, t_term;
    logic [CW-1:0]    t_val, acq_len;
    logic             sync_rise;
    logic             busy, cmd_valid, cmd_ok;

    conv_sync_rise #(.STAGES(SYNC_STAGES)) u_rise (
        .clk(clk), .rst_n(rst_n), .pin(sync_in), .rise(sync_rise)
    );

    conv_acq_lut #(.T0(ACQ_T0), .T1(ACQ_T1), .T2(ACQ_T2), .T3(ACQ_T3), .CW(CW)) u_lut (
        .sel(acq_q), .cycles(acq_len)
    );

    conv_phase_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
        .abort(t_abort), .running(t_run), .term(t_term)
    );

    // phases during which only the idle command is honoured
    assign busy      = (state == ST_CAL) || (state == ST_ZERO) ||
                       (state == ST_ACQ) || (state == ST_CONV);
    assign cmd_valid = (cfg_cmd <= 3'b100);
    assign cmd_ok    = cfg_wr && cmd_valid && (!busy || cfg_cmd == CMD_IDLE);

    // next-state, timer control and output decisions
    always_comb begin
        nxt_state = state;
        nxt_rdy   = rdy_q;
        nxt_drv   = drv_q;
        t_load    = 1'b0;
        t_abort   = 1'b0;
        t_val     = '0;
        ld_res    = 1'b0;
        if (cmd_ok) begin
            t_abort = 1'b1;
            nxt_drv = 1'b0;
            case (cmd_e'(cfg_cmd))
                CMD_SLEEP: begin nxt_state = ST_SLEEP; nxt_rdy = 1'b1; end
                CMD_CAL: begin
                    nxt_state = ST_CAL;  nxt_rdy = 1'b1;
                    t_load = 1'b1;       t_val = CW'(CAL_CLKS);
                end
                CMD_ZERO: begin
                    nxt_state = ST_ZERO; nxt_rdy = 1'b1;
                    t_load = 1'b1;       t_val = CW'(ZERO_CLKS);
                end
                CMD_IDLE:  begin nxt_state = ST_IDLE;  nxt_rdy = 1'b0; end
                default:   begin nxt_state = ST_ARMED; nxt_rdy = 1'b0; end
            endcase
        end else begin
            case (state)
                ST_CAL, ST_ZERO: begin
                    if (t_term) begin nxt_state = ST_IDLE; nxt_rdy = 1'b0; end
                end
                ST_ARMED: begin
                    if (ext_q) begin
                        if (sync_rise) begin
                            nxt_state = ST_CONV; nxt_rdy = 1'b1;
                            t_load = 1'b1;       t_val = CW'(CONV_CLKS);
                        end else if (rd_done) begin
                            nxt_rdy = 1'b1;
                        end
                    end else if (rd_done) begin
                        nxt_state = ST_ACQ; nxt_rdy = 1'b1;
                        t_load = 1'b1;      t_val = acq_len;
                    end
                end
                ST_ACQ: begin
                    if (t_term) begin
                        nxt_state = ST_CONV; nxt_drv = 1'b1;
                        t_load = 1'b1;       t_val = CW'(CONV_CLKS);
                    end
                end
                ST_CONV: begin
                    if (t_term) begin
                        nxt_state = ST_ARMED; nxt_rdy = 1'b0;
                        nxt_drv   = 1'b0;     ld_res  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // sequencer state and pad registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SLEEP;
            rdy_q <= 1'b1;
            drv_q <= 1'b0;
        end else begin
            state <= nxt_state;
            rdy_q <= nxt_rdy;
            drv_q <= nxt_drv;
        end
    end

    // mode bits latch with every accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b1;
            acq_q <= 2'b00;
        end else if (cmd_ok) begin
            ext_q <= cfg_ext_sync;
            acq_q <= cfg_acq_sel;
        end
    end

    // result capture on conversion completion
    always_ff @(posedge clk) begin
        if (!rst_n)      result_q <= '0;
        else if (ld_res) result_q <= conv_result;
    end

    assign rdy_n      = rdy_q;
    assign sync_out   = drv_q;
    assign sync_oe    = ~ext_q;
    assign phase_done = t_term;

    AST_SLEEP_RDY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_cmd == 3'b000 && !busy) |=> rdy_n); // R2
    AST_IDLE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_cmd == 3'b011) |=> (!rdy_n && !sync_out)); // R5
    AST_INPUT_PAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_oe |-> !sync_out); // R8
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && busy && cfg_cmd != 3'b011 && !t_term) |=> rdy_n); // R10
    AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && t_term && !cmd_ok) |=> (result_q == $past(conv_result))); // R7
    AST_SYNC_FALL_WITH_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_out) |-> !rdy_n); // R7

endmodule

// File: tb/conv_seq_ctrl_test.sv
module conv_seq_ctrl_test;
    localparam int RW  = 13;
    localparam int CAL = 300;
    localparam int ZR  = 78;
    localparam int CV  = 44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_cmd = 3'b000;
    logic cfg_ext_sync = 1'b0;
    logic [1:0] cfg_acq_sel = 2'b00;
    logic rd_done = 1'b0;
    logic [RW-1:0] conv_result = '0;
    logic sync_in = 1'b0;
    logic sync_out, sync_oe, rdy_n, phase_done;
    logic [RW-1:0] result_q;

    always #10 clk = ~clk;

    conv_seq_ctrl #(.CAL_CLKS(CAL)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cmd(cfg_cmd),
        .cfg_ext_sync(cfg_ext_sync), .cfg_acq_sel(cfg_acq_sel), .rd_done(rd_done),
        .conv_result(conv_result), .sync_in(sync_in), .sync_out(sync_out),
        .sync_oe(sync_oe), .rdy_n(rdy_n), .result_q(result_q), .phase_done(phase_done)
    );

    typedef struct {
        string         tag;
        int            hi_len;   // -1: not checked
        int            sy_len;
        int            dn_cnt;
        bit            chk_res;
        logic [RW-1:0] res;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [2:0] c, input logic ext, input logic [1:0] sel);
        cfg_cmd = c; cfg_ext_sync = ext; cfg_acq_sel = sel; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    task automatic sync_pulse();
        sync_in = 1'b1;
        tick(3);
        sync_in = 1'b0;
    endtask

    task automatic push(input string tag, input int hi, input int sy, input int dn,
                        input bit cr, input logic [RW-1:0] r);
        exp_t e;
        e.tag = tag; e.hi_len = hi; e.sy_len = sy; e.dn_cnt = dn; e.chk_res = cr; e.res = r;
        q.push_back(e);
    endtask

    // monitor: measures every high period of rdy_n and scores it
    int  hi_c = 0, sy_c = 0, dn_c = 0;
    bit  prev_rdy = 1'b1;
    always @(negedge clk) begin
        if (mon_on) begin
            if (rdy_n) begin
                hi_c++;
                if (sync_out)   sy_c++;
                if (phase_done) dn_c++;
            end else if (prev_rdy) begin
                if (q.size() == 0) begin
                    chk("unexpected rdy_n fall", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.hi_len >= 0) chk({e.tag, " rdy_n high cycles"}, hi_c, e.hi_len);
                    if (e.sy_len >= 0) chk({e.tag, " sync_out high cycles"}, sy_c, e.sy_len);
                    if (e.dn_cnt >= 0) chk({e.tag, " phase_done pulses"}, dn_c, e.dn_cnt);
                    if (e.chk_res)     chk({e.tag, " result_q"}, int'(result_q), int'(e.res));
                end
                hi_c = 0; sy_c = 0; dn_c = 0;
            end
            prev_rdy = rdy_n;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired, actual running expected done");
            summary();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 rdy_n", int'(rdy_n), 1);
        chk("R1 sync_oe", int'(sync_oe), 0);
        chk("R1 sync_out", int'(sync_out), 0);
        chk("R1 result_q", int'(result_q), 0);
        chk("R1 phase_done", int'(phase_done), 0);
        mon_on = 1'b1;

        // R2 leaving sleep with idle: rdy_n low at once; R8 free-running mode drives pad
        push("R2", -1, 0, 0, 1'b0, '0);
        wr_cmd(3'b011, 1'b0, 2'b00);
        chk("R2 rdy_n after idle", int'(rdy_n), 0);
        chk("R8 sync_oe free-running", int'(sync_oe), 1);

        // R4 zeroing phase
        push("R4", ZR, 0, 1, 1'b0, '0);
        wr_cmd(3'b010, 1'b0, 2'b00);
        tick(ZR + 5);

        // R3 full calibration
        push("R3", CAL, 0, 1, 1'b0, '0);
        wr_cmd(3'b001, 1'b0, 2'b00);
        tick(CAL + 5);

        // R6 free-running conversions over all four acquisition lengths; R7 capture
        for (int s = 0; s < 4; s++) begin
            int acq;
            acq = (s == 0) ? 9 : (s == 1) ? 15 : (s == 2) ? 47 : 79;
            wr_cmd(3'b100, 1'b0, 2'(s));
            conv_result = RW'(13'h0A51 + s * 13'h0123);
            push("R6", acq + CV, CV, 2, 1'b1, conv_result);
            rd_pulse();
            tick(acq + CV + 4);
        end
        wr_cmd(3'b100, 1'b0, 2'b00);

        // R12 sync_in edges do nothing in free-running mode
        sync_pulse();
        tick(10);
        chk("R12 rdy_n after sync edge", int'(rdy_n), 0);

        // R10 commands ignored mid-phase (acquisition then conversion)
        conv_result = 13'h1F0F;
        push("R10", 9 + CV, CV, 2, 1'b1, 13'h1F0F);
        rd_pulse();
        tick(3);
        wr_cmd(3'b100, 1'b1, 2'b11);
        tick(15);
        wr_cmd(3'b001, 1'b1, 2'b11);
        tick(40);
        chk("R10 mode kept", int'(sync_oe), 1);

        // R11 reserved codes ignored
        wr_cmd(3'b101, 1'b1, 2'b11);
        wr_cmd(3'b111, 1'b1, 2'b10);
        tick(2);
        chk("R11 mode kept", int'(sync_oe), 1);
        chk("R11 rdy_n", int'(rdy_n), 0);
        conv_result = 13'h0777;
        push("R11", 9 + CV, CV, 2, 1'b1, 13'h0777);
        rd_pulse();
        tick(9 + CV + 4);

        // R5 idle aborts a conversion without loading the result
        conv_result = 13'h1234;
        push("R5", -1, -1, -1, 1'b1, 13'h0777);
        rd_pulse();
        tick(20);
        wr_cmd(3'b011, 1'b0, 2'b00);
        chk("R5 rdy_n after abort", int'(rdy_n), 0);
        chk("R5 sync_out after abort", int'(sync_out), 0);
        tick(60);
        chk("R5 result kept", int'(result_q), 13'h0777);

        // R5 idle aborts calibration
        push("R5", 50, 0, 0, 1'b0, '0);
        wr_cmd(3'b001, 1'b0, 2'b00);
        tick(49);
        wr_cmd(3'b011, 1'b0, 2'b00);
        chk("R5 rdy_n after cal abort", int'(rdy_n), 0);

        // R9 externally-timed mode: edge starts conversion, select ignored
        wr_cmd(3'b100, 1'b1, 2'b11);
        chk("R8 sync_oe externally-timed", int'(sync_oe), 0);
        conv_result = 13'h1ABC;
        push("R9", CV, 0, 1, 1'b1, 13'h1ABC);
        sync_pulse();
        tick(CV + 10);

        // R9 read raises rdy_n but starts nothing
        rd_pulse();
        tick(3);
        chk("R9 rdy_n after read", int'(rdy_n), 1);
        tick(60);
        chk("R9 rdy_n still high", int'(rdy_n), 1);
        conv_result = 13'h0246;
        push("R9", -1, 0, 1, 1'b1, 13'h0246);
        sync_pulse();
        tick(CV + 10);

        // R2 sleep holds rdy_n high until another command
        wr_cmd(3'b000, 1'b1, 2'b00);
        chk("R2 rdy_n in sleep", int'(rdy_n), 1);
        tick(20);
        chk("R2 rdy_n still in sleep", int'(rdy_n), 1);
        push("R2", -1, 0, 0, 1'b0, '0);
        wr_cmd(3'b100, 1'b0, 2'b00);
        chk("R2 rdy_n after start", int'(rdy_n), 0);

        // R10 calibration length unaffected by sleep/start/zero writes
        push("R10", CAL, 0, 1, 1'b0, '0);
        wr_cmd(3'b001, 1'b0, 2'b00);
        tick(100);
        wr_cmd(3'b100, 1'b1, 2'b00);
        tick(50);
        wr_cmd(3'b000, 1'b0, 2'b00);
        wr_cmd(3'b010, 1'b0, 2'b00);
        tick(CAL);

        for (int w = 0; w < 200 && q.size() != 0; w++) tick(1);
        chk("queue drained", q.size(), 0);
        finished = 1'b1;
        summary();
    end
endmodule